// File: doc/BRIEF.md
# Hardware Queue Slot Scheduler for Oversubscribed Command Queues

Software may create more command queues than the hardware can watch at once. This block owns a small, fixed table of hardware slots and decides, once per scheduling quantum, which software queue leaves a slot and which one takes its place. Each queue has a descriptor made of its index, a priority held in a small table that only a configuration port writes, and two live status flags from the queue front end: one saying the queue holds packets and one saying it has work ready to launch.

A 3-bit mode input picks one of five policies. Three rotate through the queue list: a plain rotation that ignores queue state, one that never maps empty queues, and one that also drops a resident queue as soon as it drains. Two use priority: one maps the highest-priority ready queue into a rotating slot, the other also picks the lowest-priority or drained resident as the queue to remove. Mode and quantum length are taken only while the run input is low, so a policy change needs the block stopped. Every change of the slot table is reported on one map and one unmap strobe, each with its slot and queue index, one cycle after the decision.

Top module: `qslot_sched`

## Requirements
- R1: After reset every slot is invalid and both the map and the unmap strobe are low.
- R2: With run high and quantum length Q (0 counts as 1), a remap decision is taken on the Q-th rising edge after run rises and every Q edges after that; the strobes and slot table show it one cycle later and no map happens in between or while run is low.
- R3: Mode 0 maps the next queue not held in a slot, searching from the index after the last mapped queue and wrapping, whatever its flags say; the slot it replaces is the lowest invalid slot, else a slot pointer that moves to the slot after each one it filled.
- R4: Mode 1 works as mode 0 but never maps a queue whose non-empty flag is low, and never removes a resident queue outside a remap.
- R5: Mode 2 works as mode 1 and, in any cycle with run high and no map, clears the lowest slot whose queue has a low non-empty flag, raising unmap with that slot and queue index.
- R6: Mode 3 maps, among queues not held in a slot and with the ready flag high, the one with the largest priority value; the replaced slot is chosen as in R3.
- R7: Between candidates of equal priority the winner is the first one met when searching from the index after the last mapped queue, wrapping round the list.
- R8: When no queue is eligible at a remap, the slot table keeps its contents and neither strobe rises.
- R9: Mode 4 selects the queue as mode 3 and chooses the slot to replace as: the lowest invalid slot, else the lowest slot whose queue is empty, else the slot whose queue has the smallest priority (lowest slot on a tie); it also drains slots as in R5.
- R10: Changes on the mode and quantum inputs while run is high have no effect until run has been low for a clock edge.
- R11: A configuration write sets one queue's priority at the following edge; after reset every priority is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Scheduling enabled; low means idle and settings are sampled |
| mode_i | input | 3 | Policy: 0 rotate all, 1 rotate non-empty, 2 rotate with drain, 3 priority, 4 priority with drain |
| quantum_i | input | QW | Quantum length in cycles |
| cfg_we_i | input | 1 | Priority table write enable |
| cfg_idx_i | input | IW | Queue index written |
| cfg_prio_i | input | PW | Priority value written |
| q_nonempty_i | input | NQ | Per-queue holds-packets flag |
| q_ready_i | input | NQ | Per-queue has-ready-work flag |
| slot_valid_o | output | NS | Slot holds a queue |
| slot_qid_o | output | NS*IW | Queue index per slot, slot s at bits s*IW upward |
| map_o | output | 1 | A queue was placed in a slot |
| map_slot_o | output | SW | Slot written |
| map_qid_o | output | IW | Queue placed |
| unmap_o | output | 1 | A queue left a slot |
| unmap_slot_o | output | SW | Slot vacated or overwritten |
| unmap_qid_o | output | IW | Queue removed |

## Verification
The bench builds the block with eight queues, two slots, 4-bit priorities and an 8-bit quantum counter. With only two slots the rotating slot pointer wraps every second remap, so victim order, overwriting of a resident queue and the invalid-slot preference all show within a few quanta. Eight queues keep the search wrap-around and the start-after-last-mapped tie rule reachable with short stimulus, and a quantum of one makes every cycle a remap so each table row is a single decision.

// File: rtl/qss_pkg.sv
package qss_pkg;
  typedef enum logic [2:0] {
    SM_RR_ALL   = 3'd0,
    SM_RR_SKIP  = 3'd1,
    SM_RR_DRAIN = 3'd2,
    SM_PRI      = 3'd3,
    SM_PRI_DRAIN = 3'd4
  } sched_mode_e;
endpackage

// File: rtl/qss_quantum.sv
module qss_quantum #(
  parameter int QW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_i,
  input  logic [QW-1:0] qlen_i,
  output logic          tick_o
);
  logic [QW-1:0] cnt_q, cnt_d, qlen_eff;

  assign qlen_eff = (qlen_i == '0) ? QW'(1) : qlen_i;
  assign tick_o   = run_i && (cnt_q == qlen_eff - 1'b1);

  always_comb begin
    if (!run_i || tick_o) cnt_d = '0;
    else                  cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/qss_pick.sv
module qss_pick #(
  parameter int NQ = 16,
  parameter int PW = 4,
  parameter int IW = $clog2(NQ)
) (
  input  logic [IW-1:0]         start_i,
  input  logic [NQ-1:0]         elig_i,
  input  logic                  use_prio_i,
  input  logic [NQ-1:0][PW-1:0] prio_i,
  output logic                  found_o,
  output logic [IW-1:0]         qid_o
);
  logic [IW-1:0] idx;
  logic [PW-1:0] key, best;
  logic          hit;

  always_comb begin
    hit   = 1'b0;
    qid_o = '0;
    best  = '0;
    idx   = '0;
    key   = '0;
    for (int k = 1; k <= NQ; k++) begin
      idx = IW'((int'(start_i) + k) % NQ);
      key = use_prio_i ? prio_i[idx] : '0;
      if (elig_i[idx] && (!hit || key > best)) begin
        hit   = 1'b1;
        best  = key;
        qid_o = idx;
      end
    end
    found_o = hit;
  end
endmodule

// File: rtl/qss_victim.sv
module qss_victim #(
  parameter int NS = 4,
  parameter int IW = 4,
  parameter int PW = 4,
  parameter int SW = (NS > 1) ? $clog2(NS) : 1
) (
  input  logic [NS-1:0]         valid_i,
  input  logic [NS-1:0]         empty_i,
  input  logic [NS-1:0][PW-1:0] prio_i,
  input  logic                  use_low_i,
  input  logic [SW-1:0]         vptr_i,
  output logic [SW-1:0]         victim_o
);
  logic          got;
  logic [PW-1:0] low;

  always_comb begin
    got      = 1'b0;
    victim_o = vptr_i;
    low      = '0;
    for (int s = 0; s < NS; s++) begin
      if (!valid_i[s] && !got) begin
        got      = 1'b1;
        victim_o = SW'(s);
      end
    end
    if (!got && use_low_i) begin
      for (int s = 0; s < NS; s++) begin
        if (empty_i[s] && !got) begin
          got      = 1'b1;
          victim_o = SW'(s);
        end
      end
      if (!got) begin
        low      = prio_i[0];
        victim_o = '0;
        for (int s = 1; s < NS; s++) begin
          if (prio_i[s] < low) begin
            low      = prio_i[s];
            victim_o = SW'(s);
          end
        end
      end
    end
  end
endmodule

// File: rtl/qslot_sched.sv
module qslot_sched #(
  parameter int NQ = 16,
  parameter int NS = 4,
  parameter int PW = 4,
  parameter int QW = 16,
  parameter int IW = $clog2(NQ),
  parameter int SW = (NS > 1) ? $clog2(NS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [2:0]       mode_i,
  input  logic [QW-1:0]    quantum_i,
  input  logic             cfg_we_i,
  input  logic [IW-1:0]    cfg_idx_i,
  input  logic [PW-1:0]    cfg_prio_i,
  input  logic [NQ-1:0]    q_nonempty_i,
  input  logic [NQ-1:0]    q_ready_i,
  output logic [NS-1:0]    slot_valid_o,
  output logic [NS*IW-1:0] slot_qid_o,
  output logic             map_o,
  output logic [SW-1:0]    map_slot_o,
  output logic [IW-1:0]    map_qid_o,
  output logic             unmap_o,
  output logic [SW-1:0]    unmap_slot_o,
  output logic [IW-1:0]    unmap_qid_o
);
  import qss_pkg::*;

  sched_mode_e                 mode_q;
  logic [QW-1:0]               qlen_q;
  logic [NQ-1:0][PW-1:0]       prio_q;
  logic [NS-1:0]               slot_v_q, slot_v_d;
  logic [NS-1:0][IW-1:0]       slot_id_q, slot_id_d;
  logic [IW-1:0]               lastq_q, lastq_d;
  logic [SW-1:0]               vptr_q, vptr_d;
  logic                        map_d, unmap_d;
  logic [SW-1:0]               map_slot_d, unmap_slot_d;
  logic [IW-1:0]               map_id_d, unmap_id_d;

  logic                        tick, found, use_prio, drain_en, ev_hit;
  logic [IW-1:0]               pick;
  logic [SW-1:0]               victim, ev_slot;
  logic [NQ-1:0]               mapped, elig;
  logic [NS-1:0]               slot_empty;
  logic [NS-1:0][PW-1:0]       slot_prio;

  assign use_prio = (mode_q == SM_PRI) || (mode_q == SM_PRI_DRAIN);
  assign drain_en = (mode_q == SM_RR_DRAIN) || (mode_q == SM_PRI_DRAIN);

  for (genvar s = 0; s < NS; s++) begin : g_slot
    assign slot_empty[s]               = slot_v_q[s] && !q_nonempty_i[slot_id_q[s]];
    assign slot_prio[s]                = prio_q[slot_id_q[s]];
    assign slot_qid_o[s*IW +: IW]      = slot_id_q[s];
  end

  always_comb begin
    mapped = '0;
    for (int s = 0; s < NS; s++)
      if (slot_v_q[s]) mapped[slot_id_q[s]] = 1'b1;
  end

  always_comb begin
    case (mode_q)
      SM_RR_SKIP, SM_RR_DRAIN: elig = ~mapped & q_nonempty_i;
      SM_PRI, SM_PRI_DRAIN:    elig = ~mapped & q_ready_i;
      default:                 elig = ~mapped;
    endcase
  end

  always_comb begin
    ev_hit  = 1'b0;
    ev_slot = '0;
    for (int s = 0; s < NS; s++) begin
      if (slot_empty[s] && !ev_hit) begin
        ev_hit  = 1'b1;
        ev_slot = SW'(s);
      end
    end
  end

  qss_quantum #(.QW(QW)) quantum_i0 (
    .clk(clk), .rst_n(rst_n), .run_i(run_i), .qlen_i(qlen_q), .tick_o(tick)
  );

  qss_pick #(.NQ(NQ), .PW(PW), .IW(IW)) pick_i0 (
    .start_i(lastq_q), .elig_i(elig), .use_prio_i(use_prio),
    .prio_i(prio_q), .found_o(found), .qid_o(pick)
  );

  qss_victim #(.NS(NS), .IW(IW), .PW(PW), .SW(SW)) victim_i0 (
    .valid_i(slot_v_q), .empty_i(slot_empty), .prio_i(slot_prio),
    .use_low_i(mode_q == SM_PRI_DRAIN), .vptr_i(vptr_q), .victim_o(victim)
  );

  always_comb begin
    slot_v_d     = slot_v_q;
    slot_id_d    = slot_id_q;
    lastq_d      = lastq_q;
    vptr_d       = vptr_q;
    map_d        = 1'b0;
    map_slot_d   = '0;
    map_id_d     = '0;
    unmap_d      = 1'b0;
    unmap_slot_d = '0;
    unmap_id_d   = '0;
    if (tick && found) begin
      slot_v_d[victim]  = 1'b1;
      slot_id_d[victim] = pick;
      lastq_d           = pick;
      vptr_d            = (victim == SW'(NS - 1)) ? '0 : victim + 1'b1;
      map_d             = 1'b1;
      map_slot_d        = victim;
      map_id_d          = pick;
      unmap_d           = slot_v_q[victim];
      unmap_slot_d      = victim;
      unmap_id_d        = slot_id_q[victim];
    end else if (run_i && drain_en && ev_hit) begin
      slot_v_d[ev_slot] = 1'b0;
      unmap_d           = 1'b1;
      unmap_slot_d      = ev_slot;
      unmap_id_d        = slot_id_q[ev_slot];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q       <= SM_RR_ALL;
      qlen_q       <= QW'(1);
      prio_q       <= {NQ{PW'(1)}};
      slot_v_q     <= '0;
      slot_id_q    <= '0;
      lastq_q      <= IW'(NQ - 1);
      vptr_q       <= '0;
      map_o        <= 1'b0;
      map_slot_o   <= '0;
      map_qid_o    <= '0;
      unmap_o      <= 1'b0;
      unmap_slot_o <= '0;
      unmap_qid_o  <= '0;
    end else begin
      if (!run_i) begin
        mode_q <= sched_mode_e'(mode_i);
        qlen_q <= quantum_i;
      end
      if (cfg_we_i) prio_q[cfg_idx_i] <= cfg_prio_i;
      slot_v_q     <= slot_v_d;
      slot_id_q    <= slot_id_d;
      lastq_q      <= lastq_d;
      vptr_q       <= vptr_d;
      map_o        <= map_d;
      map_slot_o   <= map_slot_d;
      map_qid_o    <= map_id_d;
      unmap_o      <= unmap_d;
      unmap_slot_o <= unmap_slot_d;
      unmap_qid_o  <= unmap_id_d;
    end
  end

  assign slot_valid_o = slot_v_q;
endmodule

// File: rtl/qslot_sched_chk.sv
module qslot_sched_chk #(
  parameter int NQ = 16,
  parameter int NS = 4,
  parameter int IW = 4,
  parameter int SW = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run_i,
  input logic [NQ-1:0]    q_nonempty_i,
  input logic [NS-1:0]    slot_valid_o,
  input logic [NS*IW-1:0] slot_qid_o,
  input logic             map_o,
  input logic [SW-1:0]    map_slot_o,
  input logic [IW-1:0]    map_qid_o,
  input logic             unmap_o,
  input logic [SW-1:0]    unmap_slot_o,
  input logic [IW-1:0]    unmap_qid_o
);
  logic [NS-1:0]         prev_v;
  logic [NS*IW-1:0]      prev_id;
  logic [NQ-1:0]         prev_ne;
  logic                  prev_run;
  logic [NS-1:0][IW-1:0] cur_id, old_id;
  logic                  was_res;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_v   <= '0;
      prev_id  <= '0;
      prev_ne  <= '0;
      prev_run <= 1'b0;
    end else begin
      prev_v   <= slot_valid_o;
      prev_id  <= slot_qid_o;
      prev_ne  <= q_nonempty_i;
      prev_run <= run_i;
    end
  end

  always_comb begin
    was_res = 1'b0;
    for (int s = 0; s < NS; s++) begin
      cur_id[s] = slot_qid_o[s*IW +: IW];
      old_id[s] = prev_id[s*IW +: IW];
      if (prev_v[s] && old_id[s] == map_qid_o) was_res = 1'b1;
    end
  end

  AST_MAP_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
    map_o |-> !was_res); // R3
  AST_MAP_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    map_o |-> (slot_valid_o[map_slot_o] && cur_id[map_slot_o] == map_qid_o)); // R3
  AST_UNMAP_PRIOR: assert property (@(posedge clk) disable iff (!rst_n)
    unmap_o |-> (prev_v[unmap_slot_o] && old_id[unmap_slot_o] == unmap_qid_o)); // R5
  AST_DRAIN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (unmap_o && !map_o) |-> !prev_ne[unmap_qid_o]); // R5
  AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!map_o && !unmap_o) |-> (slot_valid_o == prev_v && slot_qid_o == prev_id)); // R8
  AST_IDLE_NO_MAP: assert property (@(posedge clk) disable iff (!rst_n)
    !prev_run |-> !map_o); // R2
endmodule

bind qslot_sched qslot_sched_chk #(.NQ(NQ), .NS(NS), .IW(IW), .SW(SW)) chk_i (
  .clk(clk), .rst_n(rst_n), .run_i(run_i), .q_nonempty_i(q_nonempty_i),
  .slot_valid_o(slot_valid_o), .slot_qid_o(slot_qid_o),
  .map_o(map_o), .map_slot_o(map_slot_o), .map_qid_o(map_qid_o),
  .unmap_o(unmap_o), .unmap_slot_o(unmap_slot_o), .unmap_qid_o(unmap_qid_o)
);

// File: tb/qslot_sched_tb_top.sv
module qslot_sched_tb_top;
  localparam int NQ = 8;
  localparam int NS = 2;
  localparam int PW = 4;
  localparam int QW = 8;
  localparam int IW = 3;
  localparam int SW = 1;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             run_i = 1'b0;
  logic [2:0]       mode_i = 3'd0;
  logic [QW-1:0]    quantum_i = 8'd1;
  logic             cfg_we_i = 1'b0;
  logic [IW-1:0]    cfg_idx_i = '0;
  logic [PW-1:0]    cfg_prio_i = '0;
  logic [NQ-1:0]    q_nonempty_i = '0;
  logic [NQ-1:0]    q_ready_i = '0;
  logic [NS-1:0]    slot_valid_o;
  logic [NS*IW-1:0] slot_qid_o;
  logic             map_o, unmap_o;
  logic [SW-1:0]    map_slot_o, unmap_slot_o;
  logic [IW-1:0]    map_qid_o, unmap_qid_o;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  qslot_sched #(.NQ(NQ), .NS(NS), .PW(PW), .QW(QW)) dut_i (
    .clk(clk), .rst_n(rst_n), .run_i(run_i), .mode_i(mode_i),
    .quantum_i(quantum_i), .cfg_we_i(cfg_we_i), .cfg_idx_i(cfg_idx_i),
    .cfg_prio_i(cfg_prio_i), .q_nonempty_i(q_nonempty_i), .q_ready_i(q_ready_i),
    .slot_valid_o(slot_valid_o), .slot_qid_o(slot_qid_o),
    .map_o(map_o), .map_slot_o(map_slot_o), .map_qid_o(map_qid_o),
    .unmap_o(unmap_o), .unmap_slot_o(unmap_slot_o), .unmap_qid_o(unmap_qid_o)
  );

  // ne, map, map slot, map qid, unmap, unmap qid ; mode 1, quantum 1
  localparam logic [16:0] VEC [8] = '{
    {8'b00000100, 1'b1, 1'b0, 3'd2, 1'b0, 3'd0},
    {8'b00000100, 1'b0, 1'b0, 3'd0, 1'b0, 3'd0},
    {8'b10000101, 1'b1, 1'b1, 3'd7, 1'b0, 3'd0},
    {8'b10000101, 1'b1, 1'b0, 3'd0, 1'b1, 3'd2},
    {8'b10000101, 1'b1, 1'b1, 3'd2, 1'b1, 3'd7},
    {8'b10000101, 1'b1, 1'b0, 3'd7, 1'b1, 3'd0},
    {8'b00000000, 1'b0, 1'b0, 3'd0, 1'b0, 3'd0},
    {8'b00010000, 1'b1, 1'b1, 3'd4, 1'b1, 3'd2}
  };

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic chk_map(input string req, input int slot, input int qid);
    chk({req, " map"}, int'(map_o), 1);
    chk({req, " map slot"}, int'(map_slot_o), slot);
    chk({req, " map qid"}, int'(map_qid_o), qid);
  endtask

  task automatic chk_unmap(input string req, input int qid);
    chk({req, " unmap"}, int'(unmap_o), 1);
    chk({req, " unmap qid"}, int'(unmap_qid_o), qid);
  endtask

  task automatic chk_quiet(input string req);
    chk({req, " map quiet"}, int'(map_o), 0);
    chk({req, " unmap quiet"}, int'(unmap_o), 0);
  endtask

  function automatic int qid_at(input int s);
    return int'(slot_qid_o[s*IW +: IW]);
  endfunction

  task automatic do_reset(input logic [2:0] m, input logic [QW-1:0] q);
    run_i = 1'b0;
    cfg_we_i = 1'b0;
    mode_i = m;
    quantum_i = q;
    q_nonempty_i = '0;
    q_ready_i = '0;
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic cfg_wr(input int idx, input int p);
    cfg_we_i = 1'b1;
    cfg_idx_i = IW'(idx);
    cfg_prio_i = PW'(p);
    @(negedge clk);
    cfg_we_i = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog act=expired exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b1;
    #1 rst_n = 1'b0;

    // R1 reset state
    do_reset(3'd1, 8'd1);
    chk("R1 slot_valid", int'(slot_valid_o), 0);
    chk_quiet("R1");

    // R4 table: mode 1 skips empty queues, quantum 1
    run_i = 1'b1;
    for (int i = 0; i < 8; i++) begin
      q_nonempty_i = VEC[i][16:9];
      @(negedge clk);
      chk($sformatf("R4 row%0d map", i), int'(map_o), int'(VEC[i][8]));
      if (VEC[i][8]) begin
        chk($sformatf("R4 row%0d map slot", i), int'(map_slot_o), int'(VEC[i][7]));
        chk($sformatf("R4 row%0d map qid", i), int'(map_qid_o), int'(VEC[i][6:4]));
      end
      chk($sformatf("R4 row%0d unmap", i), int'(unmap_o), int'(VEC[i][3]));
      if (VEC[i][3])
        chk($sformatf("R4 row%0d unmap qid", i), int'(unmap_qid_o), int'(VEC[i][2:0]));
    end

    // R3 mode 0 rotates regardless of empty flags
    do_reset(3'd0, 8'd1);
    run_i = 1'b1;
    @(negedge clk);
    chk_map("R3 t1", 0, 0);
    chk("R3 t1 no unmap", int'(unmap_o), 0);
    @(negedge clk);
    chk_map("R3 t2", 1, 1);
    @(negedge clk);
    chk_map("R3 t3", 0, 2);
    chk_unmap("R3 t3", 0);

    // R2 quantum 3, R10 settings ignored while running
    do_reset(3'd0, 8'd3);
    run_i = 1'b1;
    @(negedge clk);
    chk("R2 edge1 map", int'(map_o), 0);
    @(negedge clk);
    chk("R2 edge2 map", int'(map_o), 0);
    @(negedge clk);
    chk_map("R2 edge3", 0, 0);
    mode_i = 3'd3;
    quantum_i = 8'd1;
    @(negedge clk);
    chk("R10 edge4 map", int'(map_o), 0);
    @(negedge clk);
    chk("R10 edge5 map", int'(map_o), 0);
    @(negedge clk);
    chk_map("R10 edge6", 1, 1);

    // R6 / R7 / R8 / R11 priority mode 3
    do_reset(3'd3, 8'd1);
    cfg_wr(3, 5);
    cfg_wr(5, 9);
    cfg_wr(6, 9);
    q_nonempty_i = 8'hFF;
    q_ready_i = 8'b0110_1010;
    run_i = 1'b1;
    @(negedge clk);
    chk_map("R7 tie from start", 0, 5);
    @(negedge clk);
    chk_map("R6 t2", 1, 6);
    @(negedge clk);
    chk_map("R6 t3", 0, 3);
    chk_unmap("R6 t3", 5);
    cfg_we_i = 1'b1;
    cfg_idx_i = 3'd1;
    cfg_prio_i = 4'd9;
    @(negedge clk);
    chk_map("R6 t4", 1, 5);
    chk_unmap("R6 t4", 6);
    cfg_we_i = 1'b0;
    q_ready_i = 8'b0100_0010;
    @(negedge clk);
    chk_map("R7 R11 rotate after last", 0, 6);
    chk_unmap("R7 t5", 3);
    q_ready_i = 8'b0000_0000;
    @(negedge clk);
    chk_quiet("R8");
    chk("R8 valid kept", int'(slot_valid_o), 3);
    chk("R8 slot0 kept", qid_at(0), 6);
    chk("R8 slot1 kept", qid_at(1), 5);

    // R5 mode 2 drains empty resident between quanta
    do_reset(3'd2, 8'd4);
    q_nonempty_i = 8'b0000_0011;
    run_i = 1'b1;
    repeat (4) @(negedge clk);
    chk_map("R5 q4", 0, 0);
    repeat (4) @(negedge clk);
    chk_map("R5 q8", 1, 1);
    q_nonempty_i = 8'b0000_0010;
    @(negedge clk);
    chk("R5 evict map", int'(map_o), 0);
    chk_unmap("R5 evict", 0);
    chk("R5 evict slot", int'(unmap_slot_o), 0);
    chk("R5 evict valid", int'(slot_valid_o), 2);
    repeat (3) @(negedge clk);
    chk_quiet("R5 R8 no eligible");

    // R9 mode 4 victim choice
    do_reset(3'd4, 8'd1);
    cfg_wr(2, 7);
    cfg_wr(4, 3);
    cfg_wr(6, 5);
    q_nonempty_i = 8'hFF;
    q_ready_i = 8'b0101_0100;
    run_i = 1'b1;
    @(negedge clk);
    chk_map("R9 t1", 0, 2);
    @(negedge clk);
    chk_map("R9 t2", 1, 6);
    @(negedge clk);
    chk_map("R9 lowest prio victim", 1, 4);
    chk_unmap("R9 t3", 6);
    q_ready_i = 8'b0100_0000;
    @(negedge clk);
    chk_map("R9 t4", 1, 6);
    chk_unmap("R9 t4", 4);
    q_nonempty_i = 8'b1111_1011;
    q_ready_i = 8'b0001_0000;
    @(negedge clk);
    chk_map("R9 empty victim", 0, 4);
    chk_unmap("R9 t5", 2);

    run_i = 1'b0;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule